// File: doc/BRIEF.md
# Tag Downlink Command Frame Validator

This block sits behind the gap-based downlink decoder of a passive read/write tag. It receives decoded bits one at a time and a flag for any malformed field-clock run between two gaps. When the closing gap arrives it decides what the tag does next. The bit count must be one of a small set of lengths, and which lengths are legal depends on whether password mode is on. Frames that carry a password are compared against the stored password word. A write to a block whose lock bit is already set is refused.

Each frame ends in exactly one outcome. A clean write starts the programming sequencer with a one-cycle start pulse, and the captured page, block, data and new lock bit are offered alongside it. A count, pulse-stream, opcode or password fault sends the tag into regular-read mode from block 1 of the page named in the frame. A write to a locked block falls back to block-read mode on the addressed block. Other valid commands are accepted and passed on unchanged.

Top module: `rfid_cmd_check`

## Requirements
- R1: After reset, `done`, `prog_start` and `outcome` are all 0.
- R2: `frame_end` is sampled high in a cycle C. In cycle C+2, `done` is high for exactly one cycle. `outcome` is then valid with the coding 0 = accept, 1 = program, 2 = regular-read fallback, 3 = block-read fallback.
- R3: These lengths are legal. With password mode on: 70 (password write), 38 (password direct access), 34 (wake-up) and 2. With password mode off: 38 (standard write), 6 (direct access) and 2. Any other count gives outcome 2.
- R4: A frame of 70, 38 or 34 bits with password mode on carries 32 password bits, sent MSB first, directly after the 2 opcode bits. If they differ from `pwd_word`, the outcome is 2.
- R5: If `pulse_err` is seen in any cycle of the frame before the closing gap, the outcome is 2.
- R6: The first received bit must be 1, except for the 2-bit reset code `00`. In direct access frames, the bit after the opcode (or after the password) must be 0. Either violation gives outcome 2.
- R7: On outcome 2, `blk_addr` is 1. `page` is the second received bit, or 0 if fewer than two bits arrived.
- R8: Write frames use this layout: opcode (`1`, page), optional password, new lock bit, 32 data bits MSB first, 3 address bits MSB first. If `lock_bit` is high in cycle C+1 (it must reflect the block shown on `blk_addr`), the outcome is 3 and `blk_addr` keeps the addressed block.
- R9: A valid, unlocked write gives outcome 1. `prog_start` is high in the same single cycle as `done`. `blk_addr`, `page`, `wr_data` and `wr_lock` hold the captured fields.
- R10: The bit counter saturates at 127, so a 134-bit frame gives outcome 2 and does not wrap to the legal length 6.
- R11: During evaluation (cycle C+1), `bit_valid` and `frame_end` are ignored. So is a bit that arrives together with `frame_end`.
- R12: A valid wake-up, direct access, reset or read frame gives outcome 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | One decoded downlink bit this cycle |
| bit_value | input | 1 | Value of that bit |
| pulse_err | input | 1 | Malformed field-clock count seen |
| frame_end | input | 1 | Closing gap of the frame |
| pwd_mode | input | 1 | Password mode setting |
| pwd_word | input | 32 | Stored password |
| lock_bit | input | 1 | Lock bit of the block on `blk_addr` |
| done | output | 1 | Outcome valid (one cycle) |
| outcome | output | 2 | Decision code |
| prog_start | output | 1 | Start pulse for the programming sequencer |
| page | output | 1 | Page named in the frame |
| blk_addr | output | 3 | Block address (1 on regular-read fallback) |
| wr_data | output | 32 | Captured data field |
| wr_lock | output | 1 | Captured new lock bit |

## Verification
Two situations are hard to reach from the ports. The first is counter saturation: the decision only shows once a frame runs past 127 bits and would land on a legal length if the counter wrapped, so the bench sends a 134-bit frame whose tail forms a valid direct access frame. The second is the lock check, which depends on the address the block itself reports. The bench therefore drives `lock_bit` from its own lock table, indexed by `blk_addr`, and sweeps every address with both password settings. A near-exhaustive sweep over frame lengths 1 to 75, in both modes, covers every length boundary.

// File: rtl/rfid_cmd_pkg.sv
package rfid_cmd_pkg;

    localparam int OP_W = 2;

    typedef enum logic [1:0] {
        OUT_ACCEPT  = 2'd0,
        OUT_PROGRAM = 2'd1,
        OUT_REGREAD = 2'd2,
        OUT_BLKREAD = 2'd3
    } outcome_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_WRITE,
        K_WAKE,
        K_DACC,
        K_RESET,
        K_READ
    } kind_t;

endpackage

// File: rtl/rfid_cmd_shift.sv
module rfid_cmd_shift #(
    parameter int CNT_W = 7,
    parameter int SR_W  = 70
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  clr,
    input  logic                  bit_valid,
    input  logic                  bit_value,
    input  logic                  pulse_err,
    output logic [CNT_W-1:0]      cnt,
    output logic [SR_W-1:0]       sr,
    output logic [1:0]            op,
    output logic                  perr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SR_W-1:0]  sr;
        logic [1:0]       op;
        logic             perr;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (clr) begin
                st_d = '0;
            end else begin
                if (pulse_err) begin
                    st_d.perr = 1'b1;
                end
                if (bit_valid) begin
                    st_d.sr = {st_q.sr[SR_W-2:0], bit_value};
                    if (st_q.cnt == '0) begin
                        st_d.op[1] = bit_value;
                    end
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.op[0] = bit_value;
                    end
                    if (st_q.cnt != CNT_MAX) begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign sr   = st_q.sr;
    assign op   = st_q.op;
    assign perr = st_q.perr;

    // R10: a full counter stays full while more bits arrive
    a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && bit_valid && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R11: a closing gap while collecting leaves an empty frame behind
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (cnt == '0 && !perr));

endmodule

// File: rtl/rfid_cmd_decode.sv
module rfid_cmd_decode
    import rfid_cmd_pkg::*;
#(
    parameter int PWD_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 7,
    parameter int SR_W   = 70
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [SR_W-1:0]   sr,
    input  logic [1:0]        op,
    input  logic              perr,
    input  logic              pwd_mode,
    input  logic [PWD_W-1:0]  pwd_word,
    output logic              is_write,
    output logic              err,
    output logic              page,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              lockn
);
    localparam int L_WR    = OP_W + 1 + DATA_W + ADDR_W;
    localparam int L_PWR   = L_WR + PWD_W;
    localparam int L_WAKE  = OP_W + PWD_W;
    localparam int L_PDA   = OP_W + PWD_W + 1 + ADDR_W;
    localparam int L_DA    = OP_W + 1 + ADDR_W;
    localparam int L_SHORT = OP_W;
    localparam int LOCK_AT = ADDR_W + DATA_W;

    kind_t            kind;
    logic [PWD_W-1:0] pw_seen;
    logic             need_pw;
    logic             zero_ok;
    logic             op_ok;

    always_comb begin
        kind    = K_NONE;
        pw_seen = '0;
        need_pw = 1'b0;
        zero_ok = 1'b1;
        if (pwd_mode && cnt == CNT_W'(L_PWR)) begin
            kind    = K_WRITE;
            need_pw = 1'b1;
            pw_seen = sr[LOCK_AT+1 +: PWD_W];
        end else if (!pwd_mode && cnt == CNT_W'(L_WR)) begin
            kind = K_WRITE;
        end else if (pwd_mode && cnt == CNT_W'(L_PDA)) begin
            kind    = K_DACC;
            need_pw = 1'b1;
            pw_seen = sr[ADDR_W+1 +: PWD_W];
            zero_ok = !sr[ADDR_W];
        end else if (pwd_mode && cnt == CNT_W'(L_WAKE)) begin
            kind    = K_WAKE;
            need_pw = 1'b1;
            pw_seen = sr[PWD_W-1:0];
        end else if (!pwd_mode && cnt == CNT_W'(L_DA)) begin
            kind    = K_DACC;
            zero_ok = !sr[ADDR_W];
        end else if (cnt == CNT_W'(L_SHORT)) begin
            if (op == 2'b00) begin
                kind = K_RESET;
            end else if (op[1]) begin
                kind = K_READ;
            end
        end
    end

    always_comb begin
        op_ok    = (kind == K_RESET) || op[1];
        err      = perr || (kind == K_NONE) || !op_ok || !zero_ok ||
                   (need_pw && (pw_seen != pwd_word));
        is_write = (kind == K_WRITE);
        page     = op[0];
        addr     = sr[ADDR_W-1:0];
        data     = sr[ADDR_W +: DATA_W];
        lockn    = sr[LOCK_AT];
    end

    logic unused_top;
    assign unused_top = ^sr[SR_W-1 -: OP_W];

endmodule

// File: rtl/rfid_cmd_check.sv
module rfid_cmd_check
    import rfid_cmd_pkg::*;
#(
    parameter int PWD_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_value,
    input  logic              pulse_err,
    input  logic              frame_end,
    input  logic              pwd_mode,
    input  logic [PWD_W-1:0]  pwd_word,
    input  logic              lock_bit,
    output logic              done,
    output logic [1:0]        outcome,
    output logic              prog_start,
    output logic              page,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_lock
);
    localparam int SR_W = OP_W + PWD_W + 1 + DATA_W + ADDR_W;

    typedef struct packed {
        logic              eval;
        logic              page;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              lockn;
        logic              is_write;
        logic              err;
        logic              done;
        logic              prog;
        outcome_t          outcome;
    } top_t;

    top_t st_d, st_q;

    logic [CNT_W-1:0]  col_cnt;
    logic [SR_W-1:0]   col_sr;
    logic [1:0]        col_op;
    logic              col_perr;
    logic              dec_write, dec_err, dec_page, dec_lockn;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_data;

    rfid_cmd_shift #(.CNT_W(CNT_W), .SR_W(SR_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (!st_q.eval),
        .clr       (frame_end),
        .bit_valid (bit_valid),
        .bit_value (bit_value),
        .pulse_err (pulse_err),
        .cnt       (col_cnt),
        .sr        (col_sr),
        .op        (col_op),
        .perr      (col_perr)
    );

    rfid_cmd_decode #(
        .PWD_W(PWD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .SR_W(SR_W)
    ) u_decode (
        .cnt      (col_cnt),
        .sr       (col_sr),
        .op       (col_op),
        .perr     (col_perr),
        .pwd_mode (pwd_mode),
        .pwd_word (pwd_word),
        .is_write (dec_write),
        .err      (dec_err),
        .page     (dec_page),
        .addr     (dec_addr),
        .data     (dec_data),
        .lockn    (dec_lockn)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.prog = 1'b0;
        if (!st_q.eval) begin
            if (frame_end) begin
                st_d.eval     = 1'b1;
                st_d.page     = dec_page;
                st_d.addr     = dec_addr;
                st_d.data     = dec_data;
                st_d.lockn    = dec_lockn;
                st_d.is_write = dec_write;
                st_d.err      = dec_err;
            end
        end else begin
            st_d.eval = 1'b0;
            st_d.done = 1'b1;
            if (st_q.err) begin
                st_d.outcome = OUT_REGREAD;
                st_d.addr    = ADDR_W'(1);
            end else if (st_q.is_write && lock_bit) begin
                st_d.outcome = OUT_BLKREAD;
            end else if (st_q.is_write) begin
                st_d.outcome = OUT_PROGRAM;
                st_d.prog    = 1'b1;
            end else begin
                st_d.outcome = OUT_ACCEPT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done       = st_q.done;
    assign outcome    = st_q.outcome;
    assign prog_start = st_q.prog;
    assign page       = st_q.page;
    assign blk_addr   = st_q.addr;
    assign wr_data    = st_q.data;
    assign wr_lock    = st_q.lockn;

    // R2: the outcome pulse lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an outcome comes two cycles after a closing gap
    a_r2_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(frame_end, 2));

    // R9: programming never starts on a locked block
    a_r9_prog_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !$past(lock_bit));

    // R9: start pulse only together with a program outcome
    a_r9_prog_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (done && outcome == OUT_PROGRAM));

    // R7: fallback to regular read begins at block 1
    a_r7_regread_block1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == OUT_REGREAD) |-> (blk_addr == ADDR_W'(1)));

endmodule

// File: tb/rfid_cmd_check_bench.sv
module rfid_cmd_check_bench;

    localparam logic [31:0] PW = 32'hC3A5_5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0, bit_value = 1'b0, pulse_err = 1'b0, frame_end = 1'b0;
    logic        pwd_mode = 1'b0;
    logic [31:0] pwd_word = PW;
    logic        lock_bit;
    logic        done, prog_start, page, wr_lock;
    logic [1:0]  outcome;
    logic [2:0]  blk_addr;
    logic [31:0] wr_data;
    logic [7:0]  lock_mem = 8'hA0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign lock_bit = lock_mem[blk_addr];

    rfid_cmd_check u_rfid_cmd_check (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
        .pulse_err(pulse_err), .frame_end(frame_end), .pwd_mode(pwd_mode),
        .pwd_word(pwd_word), .lock_bit(lock_bit), .done(done), .outcome(outcome),
        .prog_start(prog_start), .page(page), .blk_addr(blk_addr),
        .wr_data(wr_data), .wr_lock(wr_lock)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [139:0] mk(input int n, input bit pm, input bit pg,
                                         input logic [31:0] pw, input logic [31:0] dat,
                                         input logic [2:0] ad, input bit lk);
        logic [139:0] f = '0;
        if (n == 70)            f[69:0] = {1'b1, pg, pw, lk, dat, ad};
        else if (n == 38 && !pm) f[37:0] = {1'b1, pg, lk, dat, ad};
        else if (n == 38)       f[37:0] = {1'b1, pg, pw, 1'b0, ad};
        else if (n == 34)       f[33:0] = {1'b1, pg, pw};
        else if (n == 6)        f[5:0]  = {1'b1, pg, 1'b0, ad};
        else if (n == 2)        f[1:0]  = {1'b1, pg};
        else begin
            f = 140'({dat, ~dat, dat, ~dat, dat});
            if (n >= 1) f[n-1] = 1'b1;
            if (n >= 2) f[n-2] = pg;
        end
        return f;
    endfunction

    task automatic send(input logic [139:0] f, input int n, input bit pe, input bit stray);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_value = f[n-1-i];
            pulse_err = pe && (i == n / 2);
        end
        @(negedge clk);
        bit_valid = 1'b0;
        pulse_err = 1'b0;
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = stray;
        bit_valid = stray;
        bit_value = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        bit_valid = 1'b0;
    endtask

    task automatic run_case(input string req, input int n, input bit pm,
                            input logic [139:0] f, input bit pe, input bit pw_ok,
                            input bit stray);
        bit legal, pwn, dacc, wr, opok, err;
        logic [1:0] exp_out;
        logic       exp_pg;
        legal = (n == 70 && pm) || (n == 38) || (n == 34 && pm) || (n == 6 && !pm) || (n == 2);
        pwn   = pm && (n == 70 || n == 34 || n == 38);
        dacc  = (n == 6 && !pm) || (n == 38 && pm);
        wr    = (n == 70 && pm) || (n == 38 && !pm);
        opok  = (n >= 1 && f[n-1]) || (n == 2 && f[1:0] == 2'b00);
        err   = pe || !legal || (pwn && !pw_ok) || !opok || (dacc && f[3]);
        exp_pg = (n >= 2) ? f[n-2] : 1'b0;
        if (err)                  exp_out = 2'd2;
        else if (wr && lock_mem[f[2:0]]) exp_out = 2'd3;
        else if (wr)              exp_out = 2'd1;
        else                      exp_out = 2'd0;
        pwd_mode = pm;
        send(f, n, pe, stray);
        chk({req, " R2 done"}, 64'(done), 64'd1);
        chk({req, " outcome"}, 64'(outcome), 64'(exp_out));
        chk({req, " R9 prog_start"}, 64'(prog_start), 64'(exp_out == 2'd1));
        if (exp_out == 2'd2) begin
            chk({req, " R7 block"}, 64'(blk_addr), 64'd1);
            chk({req, " R7 page"}, 64'(page), 64'(exp_pg));
        end
        if (exp_out == 2'd1 || exp_out == 2'd3) begin
            chk({req, " R8 addr"}, 64'(blk_addr), 64'(f[2:0]));
            chk({req, " R9 page"}, 64'(page), 64'(exp_pg));
        end
        if (exp_out == 2'd1) begin
            chk({req, " R9 data"}, 64'(wr_data), 64'(f[34:3]));
            chk({req, " R9 lock"}, 64'(wr_lock), 64'(f[35]));
        end
        @(negedge clk);
        chk({req, " R2 single"}, 64'({done, prog_start}), 64'd0);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [139:0] f;
        repeat (3) @(negedge clk);
        chk("R1 reset", 64'({done, prog_start, outcome}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'({done, prog_start, outcome}), 64'd0);

        // R3 R12: length sweep in both password modes
        for (int pm = 0; pm < 2; pm++) begin
            for (int n = 1; n <= 75; n++) begin
                f = mk(n, pm[0], n[0], PW, 32'h1357_9BDF ^ (32'(n) * 32'h0101_0101),
                       3'(n), n[1]);
                run_case("R3 sweep", n, pm[0], f, 1'b0, 1'b1, 1'b0);
            end
        end

        // R8 R9: writes to every address, both modes
        for (int pm = 0; pm < 2; pm++) begin
            for (int a = 0; a < 8; a++) begin
                f = mk(pm ? 70 : 38, pm[0], a[0], PW, 32'hDEAD_0000 | 32'(a), 3'(a), a[1]);
                run_case("R8 R9 write", pm ? 70 : 38, pm[0], f, 1'b0, 1'b1, 1'b0);
            end
        end

        // R4: wrong password on each password-bearing length
        run_case("R4 pw 70", 70, 1'b1, mk(70, 1'b1, 1'b0, PW ^ 32'h8000_0000, 32'h55, 3'd2, 1'b0), 1'b0, 1'b0, 1'b0);
        run_case("R4 pw 38", 38, 1'b1, mk(38, 1'b1, 1'b1, PW ^ 32'h1, 32'h0, 3'd2, 1'b0), 1'b0, 1'b0, 1'b0);
        run_case("R4 pw 34", 34, 1'b1, mk(34, 1'b1, 1'b1, PW ^ 32'h0001_0000, 32'h0, 3'd0, 1'b0), 1'b0, 1'b0, 1'b0);

        // R5: pulse stream error on an otherwise good write
        run_case("R5 pulse", 38, 1'b0, mk(38, 1'b0, 1'b1, PW, 32'hABCD, 3'd2, 1'b1), 1'b1, 1'b1, 1'b0);

        // R6: bad opcode and bad direct-access zero bit
        f = '0; f[5:0] = {1'b1, 1'b1, 1'b1, 3'd3};
        run_case("R6 da bit", 6, 1'b0, f, 1'b0, 1'b1, 1'b0);
        f = mk(38, 1'b0, 1'b1, PW, 32'h1111, 3'd1, 1'b0); f[37] = 1'b0;
        run_case("R6 opcode", 38, 1'b0, f, 1'b0, 1'b1, 1'b0);
        f = '0; f[1:0] = 2'b01;
        run_case("R6 R7 code01", 2, 1'b1, f, 1'b0, 1'b1, 1'b0);
        f = '0; f[1:0] = 2'b00;
        run_case("R12 reset", 2, 1'b0, f, 1'b0, 1'b1, 1'b0);
        f = '0; f[1:0] = 2'b11;
        run_case("R12 read", 2, 1'b1, f, 1'b0, 1'b1, 1'b0);

        // R10: 134 bits would wrap onto a legal direct access frame
        f = 140'({32'hFFFF_FFFF, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F});
        f[133] = 1'b1; f[132] = 1'b0; f[5:0] = {1'b1, 1'b0, 1'b0, 3'd4};
        run_case("R10 overlong", 134, 1'b0, f, 1'b0, 1'b1, 1'b0);

        // R11: stray bit and gap during evaluation, then a clean read
        run_case("R11 stray", 38, 1'b0, mk(38, 1'b0, 1'b0, PW, 32'h7, 3'd1, 1'b0), 1'b0, 1'b1, 1'b1);
        f = '0; f[1:0] = 2'b10;
        run_case("R11 next", 2, 1'b0, f, 1'b0, 1'b1, 1'b0);

        finish_run();
    end

endmodule